// File: doc/BRIEF.md
# Windowed Indirect Memory Read Bridge

The bridge lets a host with only a narrow, byte-wide register port read words out of a wide internal address space. It exposes two 32-bit registers in a small function register space. The first is a staging register that holds a 32-bit read address. The second is a data window that returns the word fetched from that address. The host stages the upper three address bytes first, in any order. It then writes the least significant address byte. That last write launches exactly one word read on the internal memory bus. When the read finishes, the host collects the result one byte at a time from the data window.

Internal addresses are folded into a 4 MiB space and forced to word alignment before they reach the bus. Accesses that fall outside every mapped region never reach the bus. They complete at once with a fixed marker word, so a probe of unmapped space can never stall the host. The upper address bytes stay staged between reads. A scan that walks a 256-byte span therefore needs only one byte write per word.

Top module: `win_read_bridge`

## Requirements
- R1: After reset the staging register, the data window, `busy_o`, `err_o` and `mem_req_o` are all zero.
- R2: Host register offsets 0x474..0x477 read the data window and 0x47C..0x47F read the staging register. Byte k of either register is bits 8k+7:8k. Every other offset reads 0x00.
- R3: A write to offsets 0x47D..0x47F only updates that staging byte. It issues no bus request and leaves the data window unchanged.
- R4: A write to offset 0x47C issues one bus request. The request address is the staged upper bytes combined with the written low byte, with bits 1:0 cleared and bits 31:22 cleared. The upper bytes are kept, so a later byte-0 write alone reuses them.
- R5: While a request is outstanding, `mem_req_o` and `mem_addr_o` stay constant and `busy_o` is high. The data window keeps its previous value. `busy_o` falls at the edge that accepts the response.
- R6: A response without error loads `mem_rdata_i` into the data window at the accepting edge.
- R7: A response with `mem_err_i` set loads 0xFFFFFFFF into the data window and sets `err_o`. `err_o` then stays set until reset.
- R8: The mapped regions of the folded address are [0x018000,0x030000), [0x0E0000,0x0F4000) and [0x100000,0x12E000). A trigger to any other folded address issues no request. At the trigger edge it loads 0xDEADC0DE if the folded address is below 0x040000, and 0xDEADBEEF otherwise.
- R9: A write to offset 0x47C while `busy_o` is high is ignored. The staged byte 0 keeps its value and no further request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| host_we_i | input | 1 | Host byte write strobe |
| host_addr_i | input | 12 | Host register offset |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte for `host_addr_i` |
| busy_o | output | 1 | Internal read outstanding |
| err_o | output | 1 | Sticky bus error flag |
| mem_req_o | output | 1 | Internal read request, held until response |
| mem_addr_o | output | 32 | Folded, word-aligned read address |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 32 | Response data |
| mem_err_i | input | 1 | Response carries an error |

## Verification
A corrupted staging byte shows up on `mem_addr_o` at the very next trigger edge. It also appears on the staging readback in the same cycle. A fault in the region decode appears one edge after the trigger. It shows either as a request that should not exist or as a marker word in place of fetched data. A fetch state that gets stuck or drops a request out of turn shows up within one bus response. It appears as `busy_o` failing to fall, as a changed request address, or as a window that updates while the request is still pending. A lost error flag shows up at the first access after the failing one.

// File: rtl/win_bridge_pkg.sv
package win_bridge_pkg;

   typedef enum logic [0:0] {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fetch_state_e;

   localparam logic [31:0] ERR_FILL_WORD = 32'hFFFF_FFFF;
   localparam int unsigned LANES        = 4;

endpackage

// File: rtl/win_regs.sv
module win_regs
   import win_bridge_pkg::*;
#(
   parameter int unsigned REG_AW   = 12,
   parameter int unsigned DATA_OFS = 12'h474,
   parameter int unsigned ADDR_OFS = 12'h47C
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [REG_AW-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   input  logic              busy_i,
   input  logic              load_i,
   input  logic [31:0]       load_data_i,
   output logic              trig_o,
   output logic [31:0]       trig_addr_o,
   output logic [31:0]       win_data_o
);

   logic [31:0] stage;
   logic [31:0] win_q;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic       lane_wr;
      logic [7:0] lane_q;
      if (g == 0) begin : g_trig_lane
         assign lane_wr = we_i && (addr_i == REG_AW'(ADDR_OFS)) && !busy_i;
      end else begin : g_plain_lane
         assign lane_wr = we_i && (addr_i == REG_AW'(ADDR_OFS + g));
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      lane_q <= '0;
         else if (lane_wr) lane_q <= wdata_i;
      end
      assign stage[8*g +: 8] = lane_q;
   end

   assign trig_o      = g_lane[0].lane_wr;
   assign trig_addr_o = {stage[31:8], wdata_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     win_q <= '0;
      else if (load_i) win_q <= load_data_i;
   end

   assign win_data_o = win_q;

   always_comb begin
      rdata_o = '0;
      for (int b = 0; b < LANES; b++) begin
         if (addr_i == REG_AW'(DATA_OFS + b)) rdata_o = win_q[8*b +: 8];
         if (addr_i == REG_AW'(ADDR_OFS + b)) rdata_o = stage[8*b +: 8];
      end
   end

endmodule

// File: rtl/win_decode.sv
module win_decode #(
   parameter int unsigned              ALIAS_BITS = 22,
   parameter int unsigned              NREG       = 3,
   parameter logic [NREG-1:0][31:0]    REG_BASE   = {32'h0010_0000, 32'h000E_0000, 32'h0001_8000},
   parameter logic [NREG-1:0][31:0]    REG_SIZE   = {32'h0002_E000, 32'h0001_4000, 32'h0001_8000},
   parameter logic [31:0]              LOW_SPLIT  = 32'h0004_0000,
   parameter logic [31:0]              MARK_LOW   = 32'hDEAD_C0DE,
   parameter logic [31:0]              MARK_HIGH  = 32'hDEAD_BEEF
) (
   input  logic [31:0] addr_i,
   output logic [31:0] word_addr_o,
   output logic        mapped_o,
   output logic [31:0] marker_o
);

   logic [NREG-1:0] hit;
   logic            unused_bits;

   if (ALIAS_BITS >= 32) begin : g_no_fold
      assign word_addr_o = {addr_i[31:2], 2'b00};
      assign unused_bits = ^addr_i[1:0];
   end else begin : g_fold
      assign word_addr_o = {{(32-ALIAS_BITS){1'b0}}, addr_i[ALIAS_BITS-1:2], 2'b00};
      assign unused_bits = ^{addr_i[31:ALIAS_BITS], addr_i[1:0]};
   end

   for (genvar i = 0; i < NREG; i++) begin : g_region
      assign hit[i] = (word_addr_o >= REG_BASE[i]) &&
                      ((word_addr_o - REG_BASE[i]) < REG_SIZE[i]);
   end

   assign mapped_o = |hit;
   assign marker_o = (word_addr_o < LOW_SPLIT) ? MARK_LOW : MARK_HIGH;

endmodule

// File: rtl/win_fetch.sv
module win_fetch
   import win_bridge_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        trig_i,
   input  logic        mapped_i,
   input  logic [31:0] word_addr_i,
   input  logic [31:0] marker_i,
   output logic        mem_req_o,
   output logic [31:0] mem_addr_o,
   input  logic        mem_rvalid_i,
   input  logic [31:0] mem_rdata_i,
   input  logic        mem_err_i,
   output logic        busy_o,
   output logic        err_o,
   output logic        load_o,
   output logic [31:0] load_data_o
);

   fetch_state_e state_q;
   logic [31:0]  addr_q;
   logic         err_q;
   logic         done;

   assign done = (state_q == FS_WAIT) && mem_rvalid_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            FS_IDLE: if (trig_i && mapped_i) begin
               state_q <= FS_WAIT;
               addr_q  <= word_addr_i;
            end
            FS_WAIT: if (mem_rvalid_i) begin
               state_q <= FS_IDLE;
               if (mem_err_i) err_q <= 1'b1;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   always_comb begin
      load_o      = 1'b0;
      load_data_o = mem_rdata_i;
      if (done) begin
         load_o      = 1'b1;
         load_data_o = mem_err_i ? ERR_FILL_WORD : mem_rdata_i;
      end else if (trig_i && !mapped_i && (state_q == FS_IDLE)) begin
         load_o      = 1'b1;
         load_data_o = marker_i;
      end
   end

   assign mem_req_o  = (state_q == FS_WAIT);
   assign mem_addr_o = addr_q;
   assign busy_o     = (state_q == FS_WAIT);
   assign err_o      = err_q;

endmodule

// File: rtl/win_read_bridge.sv
module win_read_bridge
   import win_bridge_pkg::*;
#(
   parameter int unsigned           REG_AW     = 12,
   parameter int unsigned           DATA_OFS   = 12'h474,
   parameter int unsigned           ADDR_OFS   = 12'h47C,
   parameter int unsigned           ALIAS_BITS = 22,
   parameter int unsigned           NREG       = 3,
   parameter logic [NREG-1:0][31:0] REG_BASE   = {32'h0010_0000, 32'h000E_0000, 32'h0001_8000},
   parameter logic [NREG-1:0][31:0] REG_SIZE   = {32'h0002_E000, 32'h0001_4000, 32'h0001_8000},
   parameter logic [31:0]           LOW_SPLIT  = 32'h0004_0000,
   parameter logic [31:0]           MARK_LOW   = 32'hDEAD_C0DE,
   parameter logic [31:0]           MARK_HIGH  = 32'hDEAD_BEEF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              host_we_i,
   input  logic [REG_AW-1:0] host_addr_i,
   input  logic [7:0]        host_wdata_i,
   output logic [7:0]        host_rdata_o,
   output logic              busy_o,
   output logic              err_o,
   output logic              mem_req_o,
   output logic [31:0]       mem_addr_o,
   input  logic              mem_rvalid_i,
   input  logic [31:0]       mem_rdata_i,
   input  logic              mem_err_i
);

   localparam int unsigned REG_SPAN = 1 << REG_AW;

   if (ALIAS_BITS < 3 || ALIAS_BITS > 32) begin : g_bad_alias
      initial $fatal(1, "ALIAS_BITS must lie in 3..32");
   end
   if ((DATA_OFS % 4) != 0 || (ADDR_OFS % 4) != 0) begin : g_bad_align
      initial $fatal(1, "register offsets must be word aligned");
   end
   if (DATA_OFS == ADDR_OFS || DATA_OFS + 4 > REG_SPAN || ADDR_OFS + 4 > REG_SPAN) begin : g_bad_ofs
      initial $fatal(1, "register offsets overlap or exceed REG_AW");
   end
   if (NREG < 1) begin : g_bad_nreg
      initial $fatal(1, "NREG must be at least 1");
   end

   logic        trig;
   logic [31:0] trig_addr;
   logic [31:0] word_addr;
   logic        mapped;
   logic [31:0] marker;
   logic        load;
   logic [31:0] load_data;
   logic [31:0] win_data;

   win_regs #(
      .REG_AW   (REG_AW),
      .DATA_OFS (DATA_OFS),
      .ADDR_OFS (ADDR_OFS)
   ) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (host_we_i),
      .addr_i      (host_addr_i),
      .wdata_i     (host_wdata_i),
      .rdata_o     (host_rdata_o),
      .busy_i      (busy_o),
      .load_i      (load),
      .load_data_i (load_data),
      .trig_o      (trig),
      .trig_addr_o (trig_addr),
      .win_data_o  (win_data)
   );

   win_decode #(
      .ALIAS_BITS (ALIAS_BITS),
      .NREG       (NREG),
      .REG_BASE   (REG_BASE),
      .REG_SIZE   (REG_SIZE),
      .LOW_SPLIT  (LOW_SPLIT),
      .MARK_LOW   (MARK_LOW),
      .MARK_HIGH  (MARK_HIGH)
   ) u_decode (
      .addr_i      (trig_addr),
      .word_addr_o (word_addr),
      .mapped_o    (mapped),
      .marker_o    (marker)
   );

   win_fetch u_fetch (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .trig_i       (trig),
      .mapped_i     (mapped),
      .word_addr_i  (word_addr),
      .marker_i     (marker),
      .mem_req_o    (mem_req_o),
      .mem_addr_o   (mem_addr_o),
      .mem_rvalid_i (mem_rvalid_i),
      .mem_rdata_i  (mem_rdata_i),
      .mem_err_i    (mem_err_i),
      .busy_o       (busy_o),
      .err_o        (err_o),
      .load_o       (load),
      .load_data_o  (load_data)
   );

endmodule

// File: rtl/win_read_bridge_chk.sv
module win_read_bridge_chk #(
   parameter int unsigned ALIAS_BITS = 22
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        busy_o,
   input logic        err_o,
   input logic        mem_req_o,
   input logic [31:0] mem_addr_o,
   input logic        mem_rvalid_i,
   input logic        mem_err_i,
   input logic [31:0] win_data
);

   AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_rvalid_i |=> mem_req_o); // R5

   AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_rvalid_i |=> $stable(mem_addr_o)); // R5

   AST_WIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_rvalid_i |=> $stable(win_data)); // R5

   AST_BUSY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_rvalid_i |=> !busy_o); // R5

   AST_ADDR_FOLDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> (mem_addr_o[1:0] == 2'b00) &&
                    ((64'(mem_addr_o) >> ALIAS_BITS) == 64'd0)); // R4

   AST_ERR_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && mem_rvalid_i && mem_err_i |=> err_o && (win_data == 32'hFFFF_FFFF)); // R7

   AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o); // R7

endmodule

bind win_read_bridge win_read_bridge_chk #(.ALIAS_BITS(ALIAS_BITS)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .busy_o       (busy_o),
   .err_o        (err_o),
   .mem_req_o    (mem_req_o),
   .mem_addr_o   (mem_addr_o),
   .mem_rvalid_i (mem_rvalid_i),
   .mem_err_i    (mem_err_i),
   .win_data     (win_data)
);

// File: tb/win_read_bridge_tb.sv
`timescale 1ns/1ps
module win_read_bridge_tb_top;

   localparam logic [31:0] ERR_ADDR = 32'h0001_B000;
   localparam int NV = 11;
   // {address, latency, kind}: kind 0 = mapped, 1 = low marker, 2 = high marker
   localparam logic [47:0] VEC [NV] = '{
      {32'h000E_0010, 8'd0, 8'd0},
      {32'h0010_0007, 8'd3, 8'd0},
      {32'h0000_0000, 8'd1, 8'd1},
      {32'h0004_0000, 8'd0, 8'd2},
      {32'h0050_0004, 8'd2, 8'd0},
      {32'hFFC1_8000, 8'd5, 8'd0},
      {32'h0012_E000, 8'd0, 8'd2},
      {32'h0003_FFFC, 8'd0, 8'd1},
      {32'h008E_0000, 8'd1, 8'd0},
      {32'h000F_4000, 8'd0, 8'd2},
      {32'h000F_3FFC, 8'd0, 8'd0}
   };

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        host_we = 1'b0;
   logic [11:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        busy, err, mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_err = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   int nreq     = 0;
   int cur_lat  = 0;
   int cnt      = 0;
   int cycles   = 0;
   bit seen     = 1'b0;
   logic [31:0] last_addr = '0;

   always #4 clk_i = ~clk_i;

   win_read_bridge dut_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .host_we_i    (host_we),
      .host_addr_i  (host_addr),
      .host_wdata_i (host_wdata),
      .host_rdata_o (host_rdata),
      .busy_o       (busy),
      .err_o        (err),
      .mem_req_o    (mem_req),
      .mem_addr_o   (mem_addr),
      .mem_rvalid_i (mem_rvalid),
      .mem_rdata_i  (mem_rdata),
      .mem_err_i    (mem_err)
   );

   function automatic logic [31:0] mem_fn(input logic [31:0] a);
      return a ^ 32'h5A00_00C3;
   endfunction

   function automatic logic [31:0] fold(input logic [31:0] a);
      return {10'b0, a[21:2], 2'b00};
   endfunction

   // memory model: answers a held request after cur_lat idle negedges
   always @(negedge clk_i) begin
      if (!rst_ni) begin
         mem_rvalid = 1'b0; mem_err = 1'b0; cnt = 0; seen = 1'b0;
      end else begin
         if (!mem_req) seen = 1'b0;
         else if (!seen) begin seen = 1'b1; nreq++; last_addr = mem_addr; end
         if (mem_rvalid) begin
            mem_rvalid = 1'b0; mem_err = 1'b0; cnt = 0;
         end else if (mem_req) begin
            if (cnt >= cur_lat) begin
               mem_rvalid = 1'b1;
               mem_rdata  = mem_fn(mem_addr);
               mem_err    = (mem_addr == ERR_ADDR);
            end else cnt++;
         end
      end
   end

   task automatic report;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk_i) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual cycles=%0d expected < 100000", cycles);
         report();
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk_i);
      host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk_i);
      host_we = 1'b0;
   endtask

   task automatic rd_word(input logic [11:0] base, output logic [31:0] w);
      for (int b = 0; b < 4; b++) begin
         @(negedge clk_i);
         host_addr = base + 12'(b);
         #1 w[8*b +: 8] = host_rdata;
      end
   endtask

   task automatic rd_byte(input logic [11:0] a, output logic [7:0] v);
      @(negedge clk_i);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   task automatic wait_idle;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk_i);
         #1;
         if (!busy) return;
      end
      check("R5 busy timeout", 32'(busy), 32'd0);
   endtask

   task automatic set_addr(input logic [31:0] a);
      wr(12'h47F, a[31:24]);
      wr(12'h47E, a[23:16]);
      wr(12'h47D, a[15:8]);
      wr(12'h47C, a[7:0]);
   endtask

   initial begin
      logic [31:0] w, prev, a, e;
      logic [7:0]  v;
      int n0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;

      // R1 reset state
      rd_word(12'h474, w); check("R1 window", w, 32'h0);
      rd_word(12'h47C, w); check("R1 staging", w, 32'h0);
      check("R1 busy/err/req", {29'b0, busy, err, mem_req}, 32'h0);

      // R3 upper bytes only: no request, window unchanged
      n0 = nreq;
      wr(12'h47F, 8'h12); wr(12'h47E, 8'h34); wr(12'h47D, 8'h56);
      repeat (3) @(negedge clk_i);
      check("R3 no request", 32'(nreq - n0), 32'd0);
      rd_word(12'h474, w); check("R3 window", w, 32'h0);
      rd_word(12'h47C, w); check("R2 staging readback", w, 32'h1234_5600);

      // table walk: R4 R6 R8
      foreach (VEC[i]) begin
         a = VEC[i][47:16];
         cur_lat = int'(VEC[i][15:8]);
         n0 = nreq;
         set_addr(a);
         wait_idle();
         case (VEC[i][7:0])
            8'd0:    e = mem_fn(fold(a));
            8'd1:    e = 32'hDEAD_C0DE;
            default: e = 32'hDEAD_BEEF;
         endcase
         rd_word(12'h474, w);
         check(VEC[i][7:0] == 8'd0 ? "R6 fetched word" : "R8 marker word", w, e);
         check(VEC[i][7:0] == 8'd0 ? "R4 one request" : "R8 no request",
               32'(nreq - n0), VEC[i][7:0] == 8'd0 ? 32'd1 : 32'd0);
         if (VEC[i][7:0] == 8'd0) check("R4 folded address", last_addr, fold(a));
      end

      // R4 reuse of staged upper bytes
      n0 = nreq;
      wr(12'h47C, 8'h00);
      wait_idle();
      rd_word(12'h474, w); check("R4 reuse data", w, mem_fn(32'h000F_3F00));
      check("R4 reuse address", last_addr, 32'h000F_3F00);
      rd_word(12'h47C, w); check("R4 staging kept", w, 32'h000F_3F00);

      // R2 unused offsets
      rd_byte(12'h470, v); check("R2 offset 470", 32'(v), 32'h0);
      rd_byte(12'h478, v); check("R2 offset 478", 32'(v), 32'h0);
      rd_byte(12'h480, v); check("R2 offset 480", 32'(v), 32'h0);

      // R7 error response and stickiness
      cur_lat = 2;
      check("R7 err clear before", 32'(err), 32'd0);
      set_addr(ERR_ADDR);
      wait_idle();
      rd_word(12'h474, w); check("R7 error fill", w, 32'hFFFF_FFFF);
      check("R7 err set", 32'(err), 32'd1);
      wr(12'h47C, 8'h04);
      wait_idle();
      rd_word(12'h474, w); check("R6 after error", w, mem_fn(32'h0001_B004));
      check("R7 err sticky", 32'(err), 32'd1);

      // R5 / R9 long access
      prev = w;
      cur_lat = 14;
      n0 = nreq;
      set_addr(32'h0010_0040);
      #1 check("R5 busy high", 32'(busy), 32'd1);
      check("R4 request address", mem_addr, 32'h0010_0040);
      rd_word(12'h474, w); check("R5 window held", w, prev);
      wr(12'h47C, 8'h80);
      #1 check("R9 still busy", 32'(busy), 32'd1);
      wait_idle();
      rd_word(12'h474, w); check("R6 long access", w, mem_fn(32'h0010_0040));
      check("R9 single request", 32'(nreq - n0), 32'd1);
      rd_byte(12'h47C, v); check("R9 byte0 kept", 32'(v), 32'h40);
      check("R5 busy low", 32'(busy), 32'd0);

      report();
   end

endmodule